// File: doc/BRIEF.md
# Maskable Interrupt Controller with Normal and Fast Outputs

The block gathers a set of interrupt request lines (32 by default) and gates each one with its own enable bit. Every enabled request is then steered, bit by bit, onto one of two processor-facing outputs: a normal interrupt line or a fast interrupt line. Both outputs are registered, so a change on a source reaches an output one clock later. A global enable bit in a control register forces both outputs low while it is clear.

The lowest nine sources (0 to 8) carry GPIO-derived requests. Bits 0 to 7 are dedicated GPIO lines, and bit 8 is the combined line from the remaining GPIOs. Software can silence all of them at once by clearing enable bits 8..0. The remaining sources are level inputs. They have no clear register: a request goes away when its source drops or when software masks it.

A simple register port gives access to the state. It has a single-cycle write strobe and a combinational read mux. Software can read the enable and route masks, the control bit, the masked pending view, and the index of the lowest-numbered pending request routed to the normal line.

Top module: `irq_route_ctl`

## Requirements
- R1: While reset is asserted and just after it, the enable mask (address 0), route mask (address 1) and control register (address 2) read as zero, and both interrupt outputs are low, whatever the sources do.
- R2: A source contributes only when its enable bit is 1. Reading address 3 returns source AND enable mask, independent of the route mask and of the global enable.
- R3: With the global enable set, the normal output in cycle n+1 equals the OR over all bits of (source AND enable AND NOT route) sampled in cycle n.
- R4: With the global enable set, the fast output in cycle n+1 equals the OR over all bits of (source AND enable AND route) sampled in cycle n. A route bit of 1 selects fast and 0 selects normal.
- R5: Control bit 0 is the global enable. While it is 0, both outputs are low on the following clock, even if requests are pending.
- R6: Reading address 4 returns, in bits [4:0], the lowest index whose (source AND enable AND NOT route) bit is set, with bit 31 set as a valid flag. When no such bit exists, it returns all zeros.
- R7: Writes to addresses 3 and 4 change no state. Control bits above bit 0 read as zero. Addresses 5 to 7 read as zero.
- R8: A level source needs no acknowledge. When it drops, the output it drove falls one clock later, with no register access.
- R9: Clearing enable bits 8..0 (value 0x1FF) blocks sources 0 to 8 while sources 9 to 31 stay enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NSRC | Interrupt request lines, active high, level |
| wr_en_i | input | 1 | Register write strobe, one cycle |
| wr_addr_i | input | 3 | Write address (0 enable, 1 route, 2 control) |
| wr_data_i | input | DW | Write data |
| rd_addr_i | input | 3 | Read address (0 to 4 valid) |
| rd_data_o | output | DW | Combinational read data |
| irq_norm_o | output | 1 | Registered normal interrupt request |
| irq_fast_o | output | 1 | Registered fast interrupt request |

## Verification
The timing properties assume the sources and the write port change only between rising edges, so each edge samples a settled value. The stimulus drives every input on the falling edge and never on a rising edge. The properties also assume the registered-output variant. The bench keeps the default parameters, so the one-cycle comparison against the previous cycle is the right one. Register writes are held for exactly one cycle, and sources are set only after the write has landed. Each expected output therefore depends on a single, known configuration.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
   localparam int unsigned ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      A_ENABLE = 3'd0,
      A_ROUTE  = 3'd1,
      A_CTRL   = 3'd2,
      A_PEND   = 3'd3,
      A_LOWEST = 3'd4
   } reg_addr_e;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
   import irq_route_pkg::*;
#(
   parameter int unsigned NSRC = 32,
   parameter int unsigned DW   = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DW-1:0]     wr_data_i,
   output logic [NSRC-1:0]   mask_o,
   output logic [NSRC-1:0]   route_o,
   output logic              en_o
);
   logic [DW-1:0] data_ext;

   always_comb data_ext = wr_data_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mask_o  <= '0;
         route_o <= '0;
         en_o    <= 1'b0;
      end else if (wr_en_i) begin
         case (reg_addr_e'(wr_addr_i))
            A_ENABLE: mask_o  <= data_ext[NSRC-1:0];
            A_ROUTE:  route_o <= data_ext[NSRC-1:0];
            A_CTRL:   en_o    <= data_ext[0];
            default:  ;
         endcase
      end
   end
endmodule

// File: rtl/irq_route_gate.sv
module irq_route_gate #(
   parameter int unsigned NSRC    = 32,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic [NSRC-1:0] src_i,
   input  logic [NSRC-1:0] mask_i,
   input  logic [NSRC-1:0] route_i,
   input  logic            en_i,
   output logic [NSRC-1:0] pend_o,
   output logic [NSRC-1:0] norm_pend_o,
   output logic            norm_o,
   output logic            fast_o
);
   logic [NSRC-1:0] fast_pend;
   logic            norm_d;
   logic            fast_d;

   always_comb begin
      pend_o      = src_i & mask_i;
      norm_pend_o = pend_o & ~route_i;
      fast_pend   = pend_o & route_i;
      norm_d      = en_i & (|norm_pend_o);
      fast_d      = en_i & (|fast_pend);
   end

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            norm_o <= 1'b0;
            fast_o <= 1'b0;
         end else begin
            norm_o <= norm_d;
            fast_o <= fast_d;
         end
      end
   end else begin : g_comb
      logic unused_clk;
      always_comb unused_clk = clk_i ^ rst_ni;
      always_comb begin
         norm_o = norm_d;
         fast_o = fast_d;
      end
   end
endmodule

// File: rtl/irq_lowest_enc.sv
module irq_lowest_enc #(
   parameter int unsigned NSRC = 32,
   localparam int unsigned IDXW = $clog2(NSRC)
) (
   input  logic [NSRC-1:0] vec_i,
   output logic [IDXW-1:0] idx_o,
   output logic            vld_o
);
   always_comb begin
      idx_o = '0;
      vld_o = 1'b0;
      for (int i = NSRC - 1; i >= 0; i--) begin
         if (vec_i[i]) begin
            idx_o = i[IDXW-1:0];
            vld_o = 1'b1;
         end
      end
   end
endmodule

// File: rtl/irq_route_ctl.sv
module irq_route_ctl
   import irq_route_pkg::*;
#(
   parameter int unsigned NSRC    = 32,
   parameter int unsigned DW      = 32,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [NSRC-1:0]   src_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DW-1:0]     wr_data_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [DW-1:0]     rd_data_o,
   output logic              irq_norm_o,
   output logic              irq_fast_o
);
   localparam int unsigned IDXW = $clog2(NSRC);

   if (NSRC < 2) begin : g_chk_nsrc
      $error("NSRC must be at least 2");
   end
   if (NSRC > DW) begin : g_chk_dw
      $error("NSRC must not exceed DW");
   end
   if (IDXW >= DW - 1) begin : g_chk_idx
      $error("index field collides with valid flag");
   end

   logic [NSRC-1:0] mask_q;
   logic [NSRC-1:0] route_q;
   logic            en_q;
   logic [NSRC-1:0] pend;
   logic [NSRC-1:0] norm_pend;
   logic [IDXW-1:0] low_idx;
   logic            low_vld;

   irq_cfg_regs #(.NSRC(NSRC), .DW(DW)) u_regs (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en_i),
      .wr_addr_i (wr_addr_i),
      .wr_data_i (wr_data_i),
      .mask_o    (mask_q),
      .route_o   (route_q),
      .en_o      (en_q)
   );

   irq_route_gate #(.NSRC(NSRC), .OUT_REG(OUT_REG)) u_gate (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .src_i       (src_i),
      .mask_i      (mask_q),
      .route_i     (route_q),
      .en_i        (en_q),
      .pend_o      (pend),
      .norm_pend_o (norm_pend),
      .norm_o      (irq_norm_o),
      .fast_o      (irq_fast_o)
   );

   irq_lowest_enc #(.NSRC(NSRC)) u_enc (
      .vec_i (norm_pend),
      .idx_o (low_idx),
      .vld_o (low_vld)
   );

   always_comb begin
      rd_data_o = '0;
      case (reg_addr_e'(rd_addr_i))
         A_ENABLE: rd_data_o[NSRC-1:0] = mask_q;
         A_ROUTE:  rd_data_o[NSRC-1:0] = route_q;
         A_CTRL:   rd_data_o[0]        = en_q;
         A_PEND:   rd_data_o[NSRC-1:0] = pend;
         A_LOWEST: begin
            rd_data_o[IDXW-1:0] = low_idx;
            rd_data_o[DW-1]     = low_vld;
         end
         default:  ;
      endcase
   end
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
   parameter int unsigned NSRC    = 32,
   parameter bit          OUT_REG = 1'b1,
   localparam int unsigned IDXW   = $clog2(NSRC)
) (
   input logic            clk_i,
   input logic            rst_ni,
   input logic [NSRC-1:0] src_i,
   input logic [NSRC-1:0] mask_q,
   input logic [NSRC-1:0] route_q,
   input logic            en_q,
   input logic [NSRC-1:0] pend,
   input logic [NSRC-1:0] norm_pend,
   input logic [IDXW-1:0] low_idx,
   input logic            low_vld,
   input logic            irq_norm_o,
   input logic            irq_fast_o
);
   logic [NSRC-1:0] below;
   always_comb below = (NSRC'(1) << low_idx) - NSRC'(1);

   // R1
   reset_quiet_chk: assert property (@(posedge clk_i)
      !rst_ni |-> (!irq_norm_o && !irq_fast_o));

   // R2
   masked_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mask_q == '0) |-> (pend == '0));

   // R5
   global_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_q |=> (!irq_norm_o && !irq_fast_o));

   // R6
   lowest_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      low_vld |-> (norm_pend[low_idx] && ((norm_pend & below) == '0)));

   // R6
   lowest_none_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !low_vld |-> (norm_pend == '0));

   if (OUT_REG) begin : g_timing
      // R3
      norm_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         1'b1 |=> (irq_norm_o == $past(en_q && |(src_i & mask_q & ~route_q))));
      // R4
      fast_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         1'b1 |=> (irq_fast_o == $past(en_q && |(src_i & mask_q & route_q))));
   end
endmodule

bind irq_route_ctl irq_route_chk #(.NSRC(NSRC), .OUT_REG(OUT_REG)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .src_i      (src_i),
   .mask_q     (mask_q),
   .route_q    (route_q),
   .en_q       (en_q),
   .pend       (pend),
   .norm_pend  (norm_pend),
   .low_idx    (low_idx),
   .low_vld    (low_vld),
   .irq_norm_o (irq_norm_o),
   .irq_fast_o (irq_fast_o)
);

// File: tb/sim_irq_route_ctl.sv
module sim_irq_route_ctl;
   localparam int NV = 7;
   localparam logic [31:0] V_SRC   [NV] = '{32'h0000_0001, 32'hFFFF_FFFF, 32'h8000_0000,
      32'h0000_0F00, 32'hFFFF_FFFF, 32'h0000_01FF, 32'h0001_0100};
   localparam logic [31:0] V_MASK  [NV] = '{32'h0000_0001, 32'h0000_0000, 32'hFFFF_FFFF,
      32'h0000_0C00, 32'hFFFF_FE00, 32'hFFFF_FE00, 32'hFFFF_FFFF};
   localparam logic [31:0] V_ROUTE [NV] = '{32'h0, 32'h0, 32'h8000_0000,
      32'h0000_0400, 32'h0, 32'h0, 32'h0000_0100};
   localparam logic [31:0] V_PEND  [NV] = '{32'h0000_0001, 32'h0, 32'h8000_0000,
      32'h0000_0C00, 32'hFFFF_FE00, 32'h0, 32'h0001_0100};
   localparam logic [31:0] V_LOW   [NV] = '{32'h8000_0000, 32'h0, 32'h0,
      32'h8000_000B, 32'h8000_0009, 32'h0, 32'h8000_0010};
   localparam logic        V_NORM  [NV] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
   localparam logic        V_FAST  [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src = '0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        irq_n;
   logic        irq_f;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   irq_route_ctl u0 (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .src_i      (src),
      .wr_en_i    (wr_en),
      .wr_addr_i  (wr_addr),
      .wr_data_i  (wr_data),
      .rd_addr_i  (rd_addr),
      .rd_data_o  (rd_data),
      .irq_norm_o (irq_n),
      .irq_fast_o (irq_f)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] r;
      src = 32'hFFFF_FFFF;
      repeat (3) @(negedge clk);
      // R1: reset state
      rd(3'd0, r); chk("R1 mask", r, 32'h0);
      rd(3'd1, r); chk("R1 route", r, 32'h0);
      rd(3'd2, r); chk("R1 ctrl", r, 32'h0);
      chk("R1 outputs", {30'h0, irq_n, irq_f}, 32'h0);
      rst_n = 1'b1;
      src = '0;
      @(negedge clk);
      chk("R1 after release", {30'h0, irq_n, irq_f}, 32'h0);

      // R5: global enable off blocks outputs, pending still visible
      wr(3'd0, 32'h0000_0003);
      wr(3'd1, 32'h0000_0002);
      src = 32'h0000_0003;
      @(negedge clk); @(negedge clk);
      chk("R5 disabled", {30'h0, irq_n, irq_f}, 32'h0);
      rd(3'd3, r); chk("R2 pend while disabled", r, 32'h3);
      wr(3'd2, 32'hFFFF_FFFF);
      @(negedge clk);
      chk("R5 enabled", {30'h0, irq_n, irq_f}, 32'h3);
      rd(3'd2, r); chk("R7 ctrl upper bits", r, 32'h1);
      wr(3'd2, 32'h0);
      @(negedge clk);
      chk("R5 re-disabled", {30'h0, irq_n, irq_f}, 32'h0);
      wr(3'd2, 32'h1);

      // R2 R3 R4 R6 R9: vector table
      for (int i = 0; i < NV; i++) begin
         wr(3'd0, V_MASK[i]);
         wr(3'd1, V_ROUTE[i]);
         src = V_SRC[i];
         @(negedge clk);
         chk("R3 norm", {31'h0, irq_n}, {31'h0, V_NORM[i]});
         chk("R4 fast", {31'h0, irq_f}, {31'h0, V_FAST[i]});
         rd(3'd3, r); chk("R2 pend", r, V_PEND[i]);
         rd(3'd4, r); chk("R6 lowest", r, V_LOW[i]);
      end
      // R9: GPIO sources silenced, upper source still reaches output
      wr(3'd0, 32'hFFFF_FE00);
      wr(3'd1, 32'h0);
      src = 32'h0000_01FF;
      @(negedge clk);
      chk("R9 gpio blocked", {31'h0, irq_n}, 32'h0);
      src = 32'h0000_0200;
      @(negedge clk);
      chk("R9 source 9 live", {31'h0, irq_n}, 32'h1);

      // R8 and R3 latency: level source, no acknowledge
      wr(3'd0, 32'h0010_0000);
      src = '0;
      @(negedge clk);
      src = 32'h0010_0000;
      #1;
      chk("R3 no early rise", {31'h0, irq_n}, 32'h0);
      @(negedge clk);
      chk("R3 rise after one clock", {31'h0, irq_n}, 32'h1);
      src = '0;
      #1;
      chk("R8 still high before edge", {31'h0, irq_n}, 32'h1);
      @(negedge clk);
      chk("R8 falls without clear", {31'h0, irq_n}, 32'h0);

      // R7: writes to read-only addresses change nothing
      wr(3'd3, 32'hFFFF_FFFF);
      wr(3'd4, 32'hFFFF_FFFF);
      rd(3'd0, r); chk("R7 mask kept", r, 32'h0010_0000);
      rd(3'd1, r); chk("R7 route kept", r, 32'h0);
      rd(3'd2, r); chk("R7 ctrl kept", r, 32'h1);
      rd(3'd3, r); chk("R7 pend", r, 32'h0);
      rd(3'd5, r); chk("R7 unused addr", r, 32'h0);
      rd(3'd7, r); chk("R7 unused addr 7", r, 32'h0);

      finish_run();
   end
endmodule